// File: doc/BRIEF.md
# DMA Channel Control Register File

This block is the software-visible register set of one DMA channel in a legacy I/O controller. It has four 32-bit words: a control/status word, a transfer address, a byte count and an upper address. They are reached through a single-cycle register bus. The bus carries word addresses, and the word index is taken from the two lowest word-address bits, so the four words repeat every 16 bytes. Reads are combinational from the stored state. Writes take effect at the next rising clock edge.

Writes to the control word are masked. The top seven bits and the low three bits are read-only. The version pattern `0xA0000000` is always present. The FIFO-drain bit is rewritten according to the value written. Writing the address word sets a read-only "address loaded" flag in the control word. The attached peripheral gives its interrupt request as a level, and that level is mirrored into the pending bit. The interrupt output is gated by the enable bit. A peripheral reset pulse and a DMA-enable level are derived from control writes.

A parameter selects one of two channel variants. The disk variant decodes every offset, with aliasing. It also advances the address word by the length of each completed transfer. The network variant decodes only byte offsets 0x00 to 0x1F. Outside that range it reads zero and ignores writes, and it ignores completed-transfer strobes.

Top module: `dma_chan_regs`

## Requirements
- R1: After synchronous reset the control word reads 0xA0000000, the other three words read 0, and `irq_out`, `periph_rst_pulse` and `dma_en_out` are low.
- R2: The word index is `bus_waddr[1:0]`: 0 is control, 1 is address, 2 is count and 3 is upper address. The disk variant aliases every word address onto these four. The network variant decodes only word addresses 0 to 7 (byte offsets 0x00 to 0x1F). At higher word addresses it reads 0 and ignores writes.
- R3: A control write keeps bits 31:25 and 2:0 from the old value and takes bits 24:3 from the written value (after the R5 adjustment). Bits 31 and 29 always read 1, and bits 28:27 and 25 always read 0.
- R4: A decoded control write with bit 7 set makes `periph_rst_pulse` high for exactly the one clock cycle after the write. Bit 7 is stored like any other writable bit.
- R5: In a control write with bit 7 clear and bit 6 set, bit 6 is stored as 0. A control write of all zeros stores bit 6 as 1.
- R6: `dma_en_out` rises when a control write sets bit 9 while it was clear, and falls when a control write clears it. Otherwise it holds.
- R7: Any decoded write to the address word sets control bit 26. Only reset clears it.
- R8: Control bit 0 (pending) equals the value `periph_irq_lvl` had at the previous clock edge. Bus writes do not change it.
- R9: `irq_out` is high exactly when control bits 0 and 4 are both set.
- R10: In the disk variant a `xfer_done` strobe adds the zero-extended `xfer_len` to the address word. A bus write to the address word in the same cycle takes priority. The network variant ignores `xfer_done`.
- R11: The count and upper-address words store the written 32-bit value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_sel | input | 1 | Register access this cycle |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_waddr | input | ADDR_W-2 | Word address (byte address bits ADDR_W-1:2) |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational |
| periph_irq_lvl | input | 1 | Peripheral interrupt request level |
| xfer_done | input | 1 | One-cycle strobe: a transfer completed |
| xfer_len | input | LEN_W | Byte length of the completed transfer |
| irq_out | output | 1 | Gated interrupt to the host |
| periph_rst_pulse | output | 1 | One-cycle reset pulse to the peripheral |
| dma_en_out | output | 1 | DMA-enable level to the peripheral |

## Verification
The bench builds two instances, one of each variant, with `ADDR_W` = 7 and `LEN_W` = 8. Both share the same stimulus. With these values the whole 32-word address space can be swept: every alias of every word in the disk variant, and the boundary between the decoded and the zero-read window in the network variant. All 32 single-bit control writes are also applied. Each one exposes the read-only mask, the drain rule and the reset-pulse and enable edges. Expected register contents come from a small arithmetic model in the bench.

// File: rtl/dma_chan_pkg.sv
package dma_chan_pkg;

   localparam int REG_W = 32;

   localparam logic [REG_W-1:0] CTRL_RO_MASK = 32'hFE00_0007;
   localparam logic [REG_W-1:0] CTRL_VERSION = 32'hA000_0000;

   localparam int BIT_PEND   = 0;
   localparam int BIT_IEN    = 4;
   localparam int BIT_DRAIN  = 6;
   localparam int BIT_PRST   = 7;
   localparam int BIT_EN     = 9;
   localparam int BIT_LOADED = 26;

   typedef enum logic [1:0] {
      IDX_CTRL  = 2'd0,
      IDX_ADDR  = 2'd1,
      IDX_COUNT = 2'd2,
      IDX_UPPER = 2'd3
   } reg_idx_e;

   // Drain-bit adjustment followed by the read-only merge
   function automatic logic [REG_W-1:0] ctrl_merge(input logic [REG_W-1:0] old_v,
                                                   input logic [REG_W-1:0] wr_v);
      logic [REG_W-1:0] w;
      w = wr_v;
      if (w[BIT_PRST]) begin
         w = w;
      end else if (w[BIT_DRAIN]) begin
         w[BIT_DRAIN] = 1'b0;
      end else if (w == '0) begin
         w[BIT_DRAIN] = 1'b1;
      end
      return (old_v & CTRL_RO_MASK) | (w & ~CTRL_RO_MASK) | CTRL_VERSION;
   endfunction

endpackage

// File: rtl/dma_win_decode.sv
module dma_win_decode
   import dma_chan_pkg::*;
#(
   parameter int ADDR_W     = 8,
   parameter bit NET_WINDOW = 1'b0
) (
   input  logic [ADDR_W-3:0] waddr,
   output reg_idx_e          idx,
   output logic              in_win
);
   localparam int WA_W = ADDR_W - 2;

   assign idx = reg_idx_e'(waddr[1:0]);

   generate
      if (NET_WINDOW) begin : g_net
         // only word addresses 0..7 (bytes 0x00..0x1F) decode
         assign in_win = (waddr[WA_W-1:3] == '0);
      end else begin : g_disk
         logic unused_hi;
         assign unused_hi = ^waddr[WA_W-1:2];
         assign in_win    = 1'b1 | unused_hi;
      end
   endgenerate
endmodule

// File: rtl/dma_ctrl_reg.sv
module dma_ctrl_reg
   import dma_chan_pkg::*;
(
   input  logic             clk,
   input  logic             rst,
   input  logic             wr_en,
   input  logic [REG_W-1:0] wdata,
   input  logic             set_loaded,
   input  logic             pend_lvl,
   output logic [REG_W-1:0] ctrl_q,
   output logic             rst_pulse
);
   logic [REG_W-1:0] ctrl_n;

   always_comb begin
      ctrl_n = ctrl_q;
      if (wr_en) begin
         ctrl_n = ctrl_merge(ctrl_q, wdata);
      end
      if (set_loaded) begin
         ctrl_n[BIT_LOADED] = 1'b1;
      end
      ctrl_n[BIT_PEND] = pend_lvl;
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         ctrl_q    <= CTRL_VERSION;
         rst_pulse <= 1'b0;
      end else begin
         ctrl_q    <= ctrl_n;
         rst_pulse <= wr_en & wdata[BIT_PRST];
      end
   end
endmodule

// File: rtl/dma_addr_reg.sv
module dma_addr_reg
   import dma_chan_pkg::*;
#(
   parameter int LEN_W   = 16,
   parameter bit ADVANCE = 1'b1
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             wr_en,
   input  logic [REG_W-1:0] wdata,
   input  logic             done,
   input  logic [LEN_W-1:0] len,
   output logic [REG_W-1:0] addr_q
);
   localparam int PAD_W = REG_W - LEN_W;

   logic [REG_W-1:0] len_ext;

   generate
      if (PAD_W > 0) begin : g_pad
         assign len_ext = {{PAD_W{1'b0}}, len};
      end else begin : g_nopad
         assign len_ext = len[REG_W-1:0];
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (rst) begin
         addr_q <= '0;
      end else if (wr_en) begin
         addr_q <= wdata;
      end else if (done && ADVANCE) begin
         addr_q <= addr_q + len_ext;
      end
   end
endmodule

// File: rtl/dma_chan_regs.sv
module dma_chan_regs
   import dma_chan_pkg::*;
#(
   parameter int ADDR_W     = 8,
   parameter int LEN_W      = 16,
   parameter bit NET_WINDOW = 1'b0
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              bus_sel,
   input  logic              bus_we,
   input  logic [ADDR_W-3:0] bus_waddr,
   input  logic [31:0]       bus_wdata,
   output logic [31:0]       bus_rdata,
   input  logic              periph_irq_lvl,
   input  logic              xfer_done,
   input  logic [LEN_W-1:0]  xfer_len,
   output logic              irq_out,
   output logic              periph_rst_pulse,
   output logic              dma_en_out
);
   localparam int NPLAIN = 2;

   generate
      if (ADDR_W < 6) begin : g_bad_addr
         $error("dma_chan_regs: ADDR_W must be at least 6");
      end
      if (LEN_W < 1 || LEN_W > REG_W) begin : g_bad_len
         $error("dma_chan_regs: LEN_W must be 1..32");
      end
   endgenerate

   reg_idx_e         idx;
   logic             in_win;
   logic             wr_any;
   logic [REG_W-1:0] ctrl_q;
   logic [REG_W-1:0] addr_q;
   logic [REG_W-1:0] plain_q [NPLAIN];

   dma_win_decode #(.ADDR_W(ADDR_W), .NET_WINDOW(NET_WINDOW)) u_dec (
      .waddr  (bus_waddr),
      .idx    (idx),
      .in_win (in_win)
   );

   assign wr_any = bus_sel & bus_we & in_win;

   dma_ctrl_reg u_ctrl (
      .clk        (clk),
      .rst        (rst),
      .wr_en      (wr_any && idx == IDX_CTRL),
      .wdata      (bus_wdata),
      .set_loaded (wr_any && idx == IDX_ADDR),
      .pend_lvl   (periph_irq_lvl),
      .ctrl_q     (ctrl_q),
      .rst_pulse  (periph_rst_pulse)
   );

   dma_addr_reg #(.LEN_W(LEN_W), .ADVANCE(!NET_WINDOW)) u_addr (
      .clk    (clk),
      .rst    (rst),
      .wr_en  (wr_any && idx == IDX_ADDR),
      .wdata  (bus_wdata),
      .done   (xfer_done),
      .len    (xfer_len),
      .addr_q (addr_q)
   );

   // count (index 2) and upper address (index 3)
   for (genvar g = 0; g < NPLAIN; g++) begin : g_plain
      always_ff @(posedge clk) begin
         if (rst) begin
            plain_q[g] <= '0;
         end else if (wr_any && idx == reg_idx_e'(g + 2)) begin
            plain_q[g] <= bus_wdata;
         end
      end
   end

   always_comb begin
      bus_rdata = '0;
      if (in_win) begin
         unique case (idx)
            IDX_CTRL:  bus_rdata = ctrl_q;
            IDX_ADDR:  bus_rdata = addr_q;
            IDX_COUNT: bus_rdata = plain_q[0];
            IDX_UPPER: bus_rdata = plain_q[1];
         endcase
      end
   end

   assign irq_out    = ctrl_q[BIT_PEND] & ctrl_q[BIT_IEN];
   assign dma_en_out = ctrl_q[BIT_EN];
endmodule

// File: rtl/dma_chan_regs_chk.sv
module dma_chan_regs_chk #(
   parameter int ADDR_W     = 8,
   parameter bit NET_WINDOW = 1'b0
) (
   input logic              clk,
   input logic              rst,
   input logic              bus_sel,
   input logic              bus_we,
   input logic [ADDR_W-3:0] bus_waddr,
   input logic [31:0]       bus_wdata,
   input logic [31:0]       bus_rdata,
   input logic              periph_irq_lvl,
   input logic              irq_out,
   input logic              periph_rst_pulse,
   input logic              dma_en_out
);
   logic far_addr;
   logic hit;
   logic ctrl_wr;
   logic ctrl_rd;

   assign far_addr = NET_WINDOW && (bus_waddr[ADDR_W-3:3] != '0);
   assign hit      = bus_sel && !far_addr;
   assign ctrl_wr  = hit && bus_we && (bus_waddr[1:0] == 2'd0);
   assign ctrl_rd  = hit && !bus_we && (bus_waddr[1:0] == 2'd0);

   p_irq_needs_req_r9: assert property (@(posedge clk) disable iff (rst)
      irq_out |-> $past(periph_irq_lvl));

   p_rst_pulse_src_r4: assert property (@(posedge clk) disable iff (rst)
      periph_rst_pulse |-> $past(ctrl_wr && bus_wdata[7]));

   p_en_rise_src_r6: assert property (@(posedge clk) disable iff (rst)
      $rose(dma_en_out) |-> $past(ctrl_wr && bus_wdata[9]));

   p_en_fall_src_r6: assert property (@(posedge clk) disable iff (rst)
      $fell(dma_en_out) |-> $past(ctrl_wr && !bus_wdata[9]));

   p_far_reads_zero_r2: assert property (@(posedge clk) disable iff (rst)
      (bus_sel && !bus_we && far_addr) |-> (bus_rdata == 32'h0));

   p_version_field_r3: assert property (@(posedge clk) disable iff (rst)
      ctrl_rd |-> (bus_rdata[31:29] == 3'b101 && bus_rdata[28:27] == 2'b00
                   && bus_rdata[25] == 1'b0));
endmodule

bind dma_chan_regs dma_chan_regs_chk #(.ADDR_W(ADDR_W), .NET_WINDOW(NET_WINDOW)) u_chk (
   .clk              (clk),
   .rst              (rst),
   .bus_sel          (bus_sel),
   .bus_we           (bus_we),
   .bus_waddr        (bus_waddr),
   .bus_wdata        (bus_wdata),
   .bus_rdata        (bus_rdata),
   .periph_irq_lvl   (periph_irq_lvl),
   .irq_out          (irq_out),
   .periph_rst_pulse (periph_rst_pulse),
   .dma_en_out       (dma_en_out)
);

// File: tb/tb_dma_chan_regs.sv
module tb_dma_chan_regs;
   localparam int AW = 7;
   localparam int LW = 8;
   localparam int WA = AW - 2;
   localparam logic [31:0] RO_MASK = 32'hFE00_0007;
   localparam logic [31:0] VER     = 32'hA000_0000;

   logic          clk = 1'b0;
   logic          rst = 1'b1;
   logic          bus_sel = 1'b0;
   logic          bus_we = 1'b0;
   logic [WA-1:0] bus_waddr = '0;
   logic [31:0]   bus_wdata = '0;
   logic          lvl = 1'b0;
   logic          xfer_done = 1'b0;
   logic [LW-1:0] xfer_len = '0;

   logic [31:0] rd_d, rd_n;
   logic irq_d, irq_n, pr_d, pr_n, en_d, en_n;

   int checks = 0;
   int fails  = 0;
   bit done_flag = 1'b0;

   logic [31:0] md [4];
   logic [31:0] mn [4];

   always #10 clk = ~clk;

   dma_chan_regs #(.ADDR_W(AW), .LEN_W(LW), .NET_WINDOW(1'b0)) dut (
      .clk(clk), .rst(rst), .bus_sel(bus_sel), .bus_we(bus_we), .bus_waddr(bus_waddr),
      .bus_wdata(bus_wdata), .bus_rdata(rd_d), .periph_irq_lvl(lvl),
      .xfer_done(xfer_done), .xfer_len(xfer_len), .irq_out(irq_d),
      .periph_rst_pulse(pr_d), .dma_en_out(en_d));

   dma_chan_regs #(.ADDR_W(AW), .LEN_W(LW), .NET_WINDOW(1'b1)) dut_net (
      .clk(clk), .rst(rst), .bus_sel(bus_sel), .bus_we(bus_we), .bus_waddr(bus_waddr),
      .bus_wdata(bus_wdata), .bus_rdata(rd_n), .periph_irq_lvl(lvl),
      .xfer_done(xfer_done), .xfer_len(xfer_len), .irq_out(irq_n),
      .periph_rst_pulse(pr_n), .dma_en_out(en_n));

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s: actual %h expected %h", tag, act, exp);
      end
   endtask

   function automatic logic [31:0] ctrl_model(input logic [31:0] old_v, input logic [31:0] v);
      logic [31:0] w;
      w = v;
      if (!w[7]) begin
         if (w[6]) w[6] = 1'b0;
         else if (w == 32'h0) w[6] = 1'b1;
      end
      return (old_v & RO_MASK) | (w & ~RO_MASK) | VER;
   endfunction

   // read one word address from both variants and compare (R2 decode)
   task automatic rd_chk(input int word, input string tag);
      logic [31:0] ed, en;
      int ix;
      ix = word % 4;
      @(negedge clk);
      bus_sel = 1'b1; bus_we = 1'b0; bus_waddr = WA'(word);
      #1;
      ed = md[ix];
      if (ix == 0) ed[0] = lvl;
      if (word >= 8) en = 32'h0;
      else begin
         en = mn[ix];
         if (ix == 0) en[0] = lvl;
      end
      chk({tag, " disk"}, rd_d, ed);
      chk({tag, " net"}, rd_n, en);
      bus_sel = 1'b0;
   endtask

   task automatic apply_wr(input int word, input logic [31:0] data, input bit net);
      int ix;
      ix = word % 4;
      if (net && word >= 8) return;
      if (net) begin
         if (ix == 0) mn[0] = ctrl_model(mn[0], data);
         else begin
            mn[ix] = data;
            if (ix == 1) mn[0][26] = 1'b1;
         end
      end else begin
         if (ix == 0) md[0] = ctrl_model(md[0], data);
         else begin
            md[ix] = data;
            if (ix == 1) md[0][26] = 1'b1;
         end
      end
   endtask

   // write, then check pulse (R4) and enable level (R6) in the next cycle
   task automatic wr(input int word, input logic [31:0] data);
      logic exp_pd, exp_pn;
      exp_pd = (word % 4 == 0) && data[7];
      exp_pn = exp_pd && (word < 8);
      @(negedge clk);
      bus_sel = 1'b1; bus_we = 1'b1; bus_waddr = WA'(word); bus_wdata = data;
      @(negedge clk);
      bus_sel = 1'b0; bus_we = 1'b0;
      apply_wr(word, data, 1'b0);
      apply_wr(word, data, 1'b1);
      chk("R4 pulse disk", {31'b0, pr_d}, {31'b0, exp_pd});
      chk("R4 pulse net",  {31'b0, pr_n}, {31'b0, exp_pn});
      chk("R6 enable disk", {31'b0, en_d}, {31'b0, md[0][9]});
      chk("R6 enable net",  {31'b0, en_n}, {31'b0, mn[0][9]});
      @(negedge clk);
      chk("R4 pulse width disk", {31'b0, pr_d}, 32'h0);
      chk("R4 pulse width net",  {31'b0, pr_n}, 32'h0);
   endtask

   task automatic set_lvl(input logic v);
      @(negedge clk);
      lvl = v;
      @(negedge clk);
      chk("R9 irq disk", {31'b0, irq_d}, {31'b0, v & md[0][4]});
      chk("R9 irq net",  {31'b0, irq_n}, {31'b0, v & mn[0][4]});
   endtask

   initial begin
      for (int i = 0; i < 4; i++) begin md[i] = 32'h0; mn[i] = 32'h0; end
      md[0] = VER; mn[0] = VER;
      repeat (3) @(negedge clk);
      rst = 1'b0;

      // R1 reset state
      chk("R1 irq",   {29'b0, irq_d, pr_d, en_d}, 32'h0);
      chk("R1 irq net", {29'b0, irq_n, pr_n, en_n}, 32'h0);
      for (int w = 0; w < 4; w++) rd_chk(w, "R1 reset read");

      // R2/R11/R7 sweep over every word address and every alias
      for (int w = 0; w < 32; w++) begin
         logic [31:0] d;
         if (w % 4 == 0) d = 32'h1 << w;
         else d = 32'h5A00_0000 ^ (w * 32'h0101_0301);
         wr(w, d);
         for (int k = 0; k < 8; k++) rd_chk(k * 4 + (w % 4), "R2 R11 R7 alias read");
      end

      // R3 R5 every single-bit control write
      for (int b = 0; b < 32; b++) begin
         wr(0, 32'h1 << b);
         rd_chk(0, "R3 R5 single bit");
      end
      wr(0, 32'h0);          rd_chk(0, "R5 zero write sets drain");
      wr(0, 32'h0000_00C0);  rd_chk(0, "R5 drain kept with reset bit");
      wr(0, 32'hFFFF_FF7F);  rd_chk(0, "R3 R5 all ones minus reset");
      wr(0, 32'hFFFF_FFFF);  rd_chk(0, "R3 all ones");

      // R6: enable via a far alias (disk only), then clear
      wr(0, 32'h0);
      wr(16, 32'h0000_0200); rd_chk(0, "R6 R2 far alias enable");
      wr(0, 32'h0000_0200);  rd_chk(0, "R6 enable both");
      wr(0, 32'h0000_0200);  rd_chk(0, "R6 enable hold");
      wr(0, 32'h0000_0100);  rd_chk(0, "R6 enable drop");

      // R8 R9 pending and gating
      set_lvl(1'b1); rd_chk(0, "R8 pending follows level");
      wr(0, 32'h0000_0010);
      chk("R9 irq after enable", {31'b0, irq_d}, 32'h1);
      rd_chk(0, "R8 pending kept on write");
      set_lvl(1'b0); rd_chk(0, "R8 pending clears");
      set_lvl(1'b1);
      wr(0, 32'h0);
      chk("R9 irq gated off", {31'b0, irq_d | irq_n}, 32'h0);
      set_lvl(1'b0);

      // R10 transfer advance
      wr(1, 32'h0000_1000);
      @(negedge clk); xfer_done = 1'b1; xfer_len = 8'h10;
      @(negedge clk); xfer_len = 8'hFF;
      @(negedge clk); xfer_done = 1'b0;
      md[1] = md[1] + 32'h10 + 32'hFF;
      rd_chk(1, "R10 advance");
      @(negedge clk);
      bus_sel = 1'b1; bus_we = 1'b1; bus_waddr = WA'(1); bus_wdata = 32'h0000_4000;
      xfer_done = 1'b1; xfer_len = 8'h20;
      @(negedge clk);
      bus_sel = 1'b0; bus_we = 1'b0; xfer_done = 1'b0;
      apply_wr(1, 32'h0000_4000, 1'b0);
      apply_wr(1, 32'h0000_4000, 1'b1);
      rd_chk(1, "R10 bus write wins");

      done_flag = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

   initial begin
      #(20 * 150000);
      if (!done_flag) begin
         fails++;
         checks++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
         $finish;
      end
   end
endmodule